// File: doc/BRIEF.md
# Receive PHY Bring-Up Sequencer

This block is a hardware state machine that powers up a receive PHY without software stepping through it. A start pulse supplies a requested line rate in Mbps and a lane count from 1 to 4. The block turns the rate into a 6-bit frequency-range code with a threshold table. If the rate, the code or the lane count is not usable, it raises an error pulse and leaves every output toward the PHY untouched.

For a usable request, the block first sets up the sideband controls and the lane enables. It then raises the test clock and pulses test clear, waiting a fixed time after each edge of clear. Last, it issues seven register writes through the PHY's test port. Each write is a two-phase handshake: the register code is latched on a falling test clock while test enable is high, and the data is taken on the following rising edge with enable low.

A power-off request given while the block is idle drops the lane enables.

Top module: `rxphy_bringup_seq`

## Requirements
- R1: The range code is taken from the first row, in ascending order of upper bound, whose bound (89, 99, 109, 129, 139, 149, 169, 179, 199, 219, 239, 249, 269, 299, 329, 359, 399, 449, 499, 549, 599, 649, 699, 749, 799, 849, 899, 949, 999, 1049, 1099, 1149, 1199, 1249, 1299, 1349, 1399, 1449, 1500) is greater than or equal to the rate. Each data-lane control register receives that code shifted left by one bit.
- R2: A start is rejected when the rate is above 1500, when the selected code is 0x00 (every rate up to 89), or when the lane count is outside 1..4. A rejected start produces a one-cycle err_o pulse in the cycle after start. busy_o stays low, and no sideband, lane-enable or test-port output changes.
- R3: On an accepted start, force-receive, force-stop and turn-request are cleared to 0 and turn-disable is set to 0xF, one cycle before lane_en_o changes. lane_en_o then takes the lowest lane-count bits set. Out of reset, force-receive and force-stop are 0xF and the other sideband outputs are 0.
- R4: The test clock is driven high before test clear rises. Test clear then stays high for exactly DELAY_CYC = CLK_MHZ*WAIT_US cycles. At least DELAY_CYC further cycles pass before the first test write begins.
- R5: Seven test writes are issued, in this order (code:data): 0x34:0x00, 0x44:code<<1, 0x54:code<<1, 0x84:code<<1, 0x94:code<<1, 0x75:0x04, 0x00:0x00.
- R6: In every test write, test_en_o is high when test_clk_o falls and low when test_clk_o rises. test_din_o holds the register code at the fall and the data at the rise, and the test clock is left high afterwards.
- R7: A start pulse that arrives while busy_o is high is ignored. The running sequence keeps its rate and lanes and completes only once.
- R8: busy_o is high from the cycle after an accepted start until the sequence ends. done_o is a single-cycle pulse in the first cycle with busy_o low.
- R9: power_off_i while idle clears lane_en_o on the next cycle and leaves the other sideband outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled when idle |
| rate_mbps_i | input | 11 | Requested rate in Mbps |
| lanes_i | input | 3 | Requested lane count |
| power_off_i | input | 1 | Drop lane enables (idle only) |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection pulse |
| lane_en_o | output | 4 | Lane enables toward the PHY |
| force_rx_o | output | 4 | Force-receive-mode per lane |
| force_stop_o | output | 4 | Force-stop-mode per lane |
| turn_req_o | output | 4 | Turnaround request per lane |
| turn_dis_o | output | 4 | Turnaround disable per lane |
| test_clk_o | output | 1 | Test-port clock |
| test_clr_o | output | 1 | Test-port clear |
| test_en_o | output | 1 | Test-port enable (code phase) |
| test_din_o | output | 8 | Test-port code/data bus |

## Verification
The bench builds the block with CLK_MHZ=1 and WAIT_US=3, so each settle wait is three cycles. A full bring-up therefore takes about sixty cycles. That makes it practical to run a complete sequence at both sides of every one of the 39 table boundaries, with all four lane counts in rotation. It also leaves room for the rejection cases, a start injected mid-sequence, and power-off with the clear-pulse width measured exactly.

// File: rtl/rxphy_pkg.sv
package rxphy_pkg;

   typedef enum logic [3:0] {
      SQ_IDLE, SQ_SIDEBAND, SQ_LANES, SQ_ARM, SQ_CLR_SET,
      SQ_CLR_HI, SQ_CLR_LO, SQ_WR_GO, SQ_WR_WAIT
   } seq_state_t;

   typedef enum logic [2:0] {
      TW_IDLE, TW_FALL, TW_ENLO, TW_DATA, TW_RISE
   } tw_state_t;

   localparam int RANGE_ROWS = 39;
   localparam int NUM_WRITES = 7;

   // Ascending upper bounds of the frequency ranges, in Mbps.
   function automatic int range_top(input int idx);
      case (idx)
         0: return 89;    1: return 99;    2: return 109;   3: return 129;
         4: return 139;   5: return 149;   6: return 169;   7: return 179;
         8: return 199;   9: return 219;   10: return 239;  11: return 249;
         12: return 269;  13: return 299;  14: return 329;  15: return 359;
         16: return 399;  17: return 449;  18: return 499;  19: return 549;
         20: return 599;  21: return 649;  22: return 699;  23: return 749;
         24: return 799;  25: return 849;  26: return 899;  27: return 949;
         28: return 999;  29: return 1049; 30: return 1099; 31: return 1149;
         32: return 1199; 33: return 1249; 34: return 1299; 35: return 1349;
         36: return 1399; 37: return 1449; default: return 1500;
      endcase
   endfunction

   // 6-bit range code for each row.
   function automatic logic [5:0] range_code(input int idx);
      case (idx)
         0: return 6'h00;  1: return 6'h10;  2: return 6'h20;  3: return 6'h01;
         4: return 6'h11;  5: return 6'h21;  6: return 6'h02;  7: return 6'h12;
         8: return 6'h22;  9: return 6'h03;  10: return 6'h13; 11: return 6'h23;
         12: return 6'h04; 13: return 6'h14; 14: return 6'h05; 15: return 6'h15;
         16: return 6'h25; 17: return 6'h06; 18: return 6'h16; 19: return 6'h07;
         20: return 6'h17; 21: return 6'h08; 22: return 6'h18; 23: return 6'h09;
         24: return 6'h19; 25: return 6'h29; 26: return 6'h39; 27: return 6'h0a;
         28: return 6'h1a; 29: return 6'h2a; 30: return 6'h3a; 31: return 6'h0b;
         32: return 6'h1b; 33: return 6'h2b; 34: return 6'h3b; 35: return 6'h0c;
         36: return 6'h1c; 37: return 6'h2c; default: return 6'h3c;
      endcase
   endfunction

   // Register code of each step of the programming sequence.
   function automatic logic [7:0] step_reg(input int idx);
      case (idx)
         0: return 8'h34;  1: return 8'h44;  2: return 8'h54;  3: return 8'h84;
         4: return 8'h94;  5: return 8'h75;  default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/rxphy_rate_lookup.sv
module rxphy_rate_lookup #(
   parameter int RATE_W    = 11,
   parameter int MAX_LANES = 4,
   localparam int LANE_W   = $clog2(MAX_LANES + 1)
) (
   input  logic [RATE_W-1:0]    rate_i,
   input  logic [LANE_W-1:0]    lanes_i,
   output logic [5:0]           code_o,
   output logic [MAX_LANES-1:0] mask_o,
   output logic                 bad_o
);
   import rxphy_pkg::*;

   logic hit;
   logic lanes_ok;

   // Priority pick: walking down, the lowest matching row wins.
   always_comb begin
      code_o = '0;
      hit    = 1'b0;
      for (int i = RANGE_ROWS - 1; i >= 0; i--) begin
         if (int'(rate_i) <= range_top(i)) begin
            code_o = range_code(i);
            hit    = 1'b1;
         end
      end
   end

   assign lanes_ok = (int'(lanes_i) >= 1) && (int'(lanes_i) <= MAX_LANES);

   always_comb begin
      for (int l = 0; l < MAX_LANES; l++)
         mask_o[l] = lanes_ok && (l < int'(lanes_i));
   end

   assign bad_o = !hit || (code_o == 6'h00) || !lanes_ok;

endmodule

// File: rtl/rxphy_test_writer.sv
module rxphy_test_writer (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm_i,
   input  logic       go_i,
   input  logic [7:0] code_i,
   input  logic [7:0] data_i,
   output logic       ack_o,
   output logic       test_clk_o,
   output logic       test_en_o,
   output logic [7:0] test_din_o
);
   import rxphy_pkg::*;

   tw_state_t st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= TW_IDLE;
         ack_o      <= 1'b0;
         test_clk_o <= 1'b0;
         test_en_o  <= 1'b0;
         test_din_o <= '0;
      end else begin
         ack_o <= 1'b0;
         case (st)
            TW_IDLE: begin
               if (arm_i) test_clk_o <= 1'b1;
               if (go_i) begin
                  test_din_o <= code_i;
                  test_en_o  <= 1'b1;
                  st         <= TW_FALL;
               end
            end
            TW_FALL: begin
               test_clk_o <= 1'b0;
               st         <= TW_ENLO;
            end
            TW_ENLO: begin
               test_en_o <= 1'b0;
               st        <= TW_DATA;
            end
            TW_DATA: begin
               test_din_o <= data_i;
               st         <= TW_RISE;
            end
            default: begin
               test_clk_o <= 1'b1;
               ack_o      <= 1'b1;
               st         <= TW_IDLE;
            end
         endcase
      end
   end

   // R6
   code_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(test_clk_o) |-> test_en_o);
   // R6
   data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_clk_o) |-> !test_en_o);
   // R5
   go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> (st == TW_IDLE));

endmodule

// File: rtl/rxphy_bringup_seq.sv
module rxphy_bringup_seq #(
   parameter int CLK_MHZ   = 100,
   parameter int WAIT_US   = 100,
   parameter int RATE_W    = 11,
   parameter int MAX_LANES = 4,
   localparam int LANE_W   = $clog2(MAX_LANES + 1),
   localparam int DELAY_CYC = CLK_MHZ * WAIT_US,
   localparam int CNT_W    = $clog2(DELAY_CYC + 1),
   localparam int IDX_W    = $clog2(rxphy_pkg::NUM_WRITES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [RATE_W-1:0]    rate_mbps_i,
   input  logic [LANE_W-1:0]    lanes_i,
   input  logic                 power_off_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic                 err_o,
   output logic [MAX_LANES-1:0] lane_en_o,
   output logic [MAX_LANES-1:0] force_rx_o,
   output logic [MAX_LANES-1:0] force_stop_o,
   output logic [MAX_LANES-1:0] turn_req_o,
   output logic [MAX_LANES-1:0] turn_dis_o,
   output logic                 test_clk_o,
   output logic                 test_clr_o,
   output logic                 test_en_o,
   output logic [7:0]           test_din_o
);
   import rxphy_pkg::*;

   initial begin
      if (DELAY_CYC < 1) $error("settle wait must be at least one cycle");
      if (MAX_LANES != 4) $error("sequence programs exactly four data lanes");
      if (RATE_W < 11) $error("rate width too narrow for the table");
   end

   seq_state_t           st;
   logic [CNT_W-1:0]     cnt;
   logic [IDX_W-1:0]     idx;
   logic [5:0]           code_q;
   logic [MAX_LANES-1:0] mask_q;
   logic [5:0]           lk_code;
   logic [MAX_LANES-1:0] lk_mask;
   logic                 lk_bad;
   logic                 arm;
   logic                 go;
   logic                 ack;
   logic [7:0]           wr_code;
   logic [7:0]           wr_data;

   rxphy_rate_lookup #(.RATE_W(RATE_W), .MAX_LANES(MAX_LANES)) u_lookup (
      .rate_i (rate_mbps_i),
      .lanes_i(lanes_i),
      .code_o (lk_code),
      .mask_o (lk_mask),
      .bad_o  (lk_bad)
   );

   assign arm = (st == SQ_ARM);
   assign go  = (st == SQ_WR_GO);

   always_comb begin
      wr_code = step_reg(int'(idx));
      case (int'(idx))
         0, 6:    wr_data = 8'h00;
         5:       wr_data = 8'h04;
         default: wr_data = {1'b0, code_q, 1'b0};
      endcase
   end

   rxphy_test_writer u_writer (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (arm),
      .go_i      (go),
      .code_i    (wr_code),
      .data_i    (wr_data),
      .ack_o     (ack),
      .test_clk_o(test_clk_o),
      .test_en_o (test_en_o),
      .test_din_o(test_din_o)
   );

   assign busy_o = (st != SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= SQ_IDLE;
         cnt          <= '0;
         idx          <= '0;
         code_q       <= '0;
         mask_q       <= '0;
         done_o       <= 1'b0;
         err_o        <= 1'b0;
         lane_en_o    <= '0;
         force_rx_o   <= '1;
         force_stop_o <= '1;
         turn_req_o   <= '0;
         turn_dis_o   <= '0;
         test_clr_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         case (st)
            SQ_IDLE: begin
               if (start_i) begin
                  if (lk_bad) begin
                     err_o <= 1'b1;
                  end else begin
                     code_q <= lk_code;
                     mask_q <= lk_mask;
                     st     <= SQ_SIDEBAND;
                  end
               end else if (power_off_i) begin
                  lane_en_o <= '0;
               end
            end
            SQ_SIDEBAND: begin
               force_rx_o   <= '0;
               force_stop_o <= '0;
               turn_req_o   <= '0;
               turn_dis_o   <= '1;
               st           <= SQ_LANES;
            end
            SQ_LANES: begin
               lane_en_o <= mask_q;
               st        <= SQ_ARM;
            end
            SQ_ARM: st <= SQ_CLR_SET;
            SQ_CLR_SET: begin
               test_clr_o <= 1'b1;
               cnt        <= CNT_W'(DELAY_CYC - 1);
               st         <= SQ_CLR_HI;
            end
            SQ_CLR_HI: begin
               if (cnt == '0) begin
                  test_clr_o <= 1'b0;
                  cnt        <= CNT_W'(DELAY_CYC - 1);
                  st         <= SQ_CLR_LO;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            SQ_CLR_LO: begin
               if (cnt == '0) begin
                  idx <= '0;
                  st  <= SQ_WR_GO;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            SQ_WR_GO: st <= SQ_WR_WAIT;
            default: begin
               if (ack) begin
                  if (int'(idx) == NUM_WRITES - 1) begin
                     done_o <= 1'b1;
                     st     <= SQ_IDLE;
                  end else begin
                     idx <= idx + 1'b1;
                     st  <= SQ_WR_GO;
                  end
               end
            end
         endcase
      end
   end

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);
   // R2
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!busy_o && $stable(lane_en_o) && $stable(test_clk_o)));
   // R3
   lanes_after_sideband_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lane_en_o) == '0 && lane_en_o != '0) |->
         (turn_dis_o == '1 && force_rx_o == '0 && force_stop_o == '0 && turn_req_o == '0));
   // R4
   clr_under_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(test_clr_o) |-> test_clk_o);
   // R4
   no_write_in_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      test_clr_o |-> !test_en_o);

endmodule

// File: tb/rxphy_bringup_seq_bench.sv
module rxphy_bringup_seq_bench;
   localparam int D = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [10:0] rate_mbps_i = '0;
   logic [2:0] lanes_i = '0;
   logic power_off_i = 1'b0;
   logic busy_o, done_o, err_o, test_clk_o, test_clr_o, test_en_o;
   logic [3:0] lane_en_o, force_rx_o, force_stop_o, turn_req_o, turn_dis_o;
   logic [7:0] test_din_o;

   always #5 clk = ~clk;

   rxphy_bringup_seq #(.CLK_MHZ(1), .WAIT_US(D)) u_rxphy_bringup_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rate_mbps_i(rate_mbps_i),
      .lanes_i(lanes_i), .power_off_i(power_off_i), .busy_o(busy_o),
      .done_o(done_o), .err_o(err_o), .lane_en_o(lane_en_o),
      .force_rx_o(force_rx_o), .force_stop_o(force_stop_o),
      .turn_req_o(turn_req_o), .turn_dis_o(turn_dis_o),
      .test_clk_o(test_clk_o), .test_clr_o(test_clr_o),
      .test_en_o(test_en_o), .test_din_o(test_din_o));

   int checks = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   int bounds[39];
   int codes[39];

   // Monitor of test-port transactions, sampled at the falling clock edge.
   logic [7:0] cap_code[8];
   logic [7:0] cap_data[8];
   int ncap = 0;
   int ndone = 0;
   int clr_hi_len = -1;
   int clr_run = 0;
   int low_gap = 0;
   int first_gap = -1;
   bit pend = 0;
   bit hs_bad = 0;
   logic prev_tclk = 0;
   logic prev_clr = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (done_o) ndone++;
         if (test_clr_o) clr_run++;
         if (prev_clr && !test_clr_o) begin
            clr_hi_len = clr_run;
            low_gap = 0;
         end
         if (!test_clr_o) low_gap++;
         if (!prev_clr && test_clr_o) clr_run = 1;
         if (prev_tclk && !test_clk_o) begin
            if (!test_en_o) hs_bad = 1;
            if (ncap == 0) first_gap = low_gap;
            if (ncap < 8) cap_code[ncap] = test_din_o;
            pend = 1;
         end
         if (!prev_tclk && test_clk_o && pend) begin
            if (test_en_o) hs_bad = 1;
            if (ncap < 8) cap_data[ncap] = test_din_o;
            ncap++;
            pend = 0;
         end
         prev_tclk = test_clk_o;
         prev_clr = test_clr_o;
      end
   end

   function automatic int exp_code(input int rate);
      for (int i = 0; i < 39; i++)
         if (bounds[i] >= rate) return codes[i];
      return 0;
   endfunction

   task automatic clear_mon();
      ncap = 0; ndone = 0; clr_hi_len = -1; first_gap = -1; hs_bad = 0; pend = 0;
   endtask

   task automatic run(input int rate, input int lanes, input bit interfere);
      int c;
      bit bad;
      logic [3:0] lane0;
      logic [7:0] ea[7];
      logic [7:0] ed[7];
      c = exp_code(rate);
      bad = (rate > 1500) || (c == 0) || (lanes < 1) || (lanes > 4);
      lane0 = lane_en_o;
      clear_mon();
      @(negedge clk);
      start_i = 1; rate_mbps_i = 11'(rate); lanes_i = 3'(lanes);
      @(negedge clk);
      start_i = 0;
      if (bad) begin
         chk(err_o == 1 && busy_o == 0, "R2 err pulse", {err_o, busy_o}, 2);
         @(negedge clk);
         chk(err_o == 0, "R2 err single", err_o, 0);
         repeat (10) @(negedge clk);
         chk(ncap == 0 && lane_en_o == lane0 && busy_o == 0 && clr_hi_len == -1,
             "R2 no activity", ncap, 0);
         return;
      end
      chk(busy_o == 1 && err_o == 0, "R8 busy after start", busy_o, 1);
      if (interfere) begin
         repeat (4) @(negedge clk);
         start_i = 1; rate_mbps_i = 11'd1500; lanes_i = 3'd1;
         @(negedge clk);
         start_i = 0;
      end
      for (int k = 0; k < 400 && busy_o; k++) @(negedge clk);
      chk(done_o == 1, "R8 done with busy low", done_o, 1);
      repeat (20) @(negedge clk);
      chk(ndone == 1 && !busy_o, "R7 single completion", ndone, 1);
      ea = '{8'h34, 8'h44, 8'h54, 8'h84, 8'h94, 8'h75, 8'h00};
      for (int i = 0; i < 7; i++) ed[i] = 8'(c * 2);
      ed[0] = 8'h00; ed[5] = 8'h04; ed[6] = 8'h00;
      chk(ncap == 7, "R5 write count", ncap, 7);
      for (int i = 0; i < 7; i++) begin
         chk(cap_code[i] == ea[i], "R5 write order", cap_code[i], ea[i]);
         chk(cap_data[i] == ed[i], "R1 write data", cap_data[i], ed[i]);
      end
      chk(!hs_bad && test_clk_o == 1 && test_en_o == 0, "R6 handshake", hs_bad, 0);
      chk(clr_hi_len == D, "R4 clear width", clr_hi_len, D);
      chk(first_gap >= D && test_clr_o == 0, "R4 settle before write", first_gap, D);
      chk(lane_en_o == 4'((1 << lanes) - 1), "R3 lane mask", lane_en_o, (1 << lanes) - 1);
      chk(force_rx_o == 0 && force_stop_o == 0 && turn_req_o == 0 && turn_dis_o == 4'hF,
          "R3 sideband", {force_rx_o, force_stop_o, turn_req_o, turn_dis_o}, 16'h000F);
   endtask

   initial begin
      bounds = '{89, 99, 109, 129, 139, 149, 169, 179, 199, 219, 239, 249, 269,
                 299, 329, 359, 399, 449, 499, 549, 599, 649, 699, 749, 799, 849,
                 899, 949, 999, 1049, 1099, 1149, 1199, 1249, 1299, 1349, 1399,
                 1449, 1500};
      codes = '{'h00, 'h10, 'h20, 'h01, 'h11, 'h21, 'h02, 'h12, 'h22, 'h03,
                'h13, 'h23, 'h04, 'h14, 'h05, 'h15, 'h25, 'h06, 'h16, 'h07,
                'h17, 'h08, 'h18, 'h09, 'h19, 'h29, 'h39, 'h0a, 'h1a, 'h2a,
                'h3a, 'h0b, 'h1b, 'h2b, 'h3b, 'h0c, 'h1c, 'h2c, 'h3c};
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R3 reset state
      chk(busy_o == 0 && done_o == 0 && err_o == 0 && lane_en_o == 0 &&
          force_rx_o == 4'hF && force_stop_o == 4'hF && turn_dis_o == 0 &&
          test_clk_o == 0 && test_clr_o == 0, "R3 reset state", lane_en_o, 0);
      // R2 rejections: low rates, out-of-range rate, bad lane counts
      run(0, 2, 0);
      run(89, 4, 0);
      run(1501, 1, 0);
      run(2047, 3, 0);
      run(500, 0, 0);
      run(500, 5, 0);
      // R1 every boundary and the rate just above it
      for (int i = 1; i < 39; i++) begin
         run(bounds[i], (i % 4) + 1, 0);
         run(bounds[i - 1] + 1, ((i + 1) % 4) + 1, 0);
      end
      // R7 start while busy
      run(700, 3, 1);
      run(129, 2, 1);
      // R9 power-off while idle
      @(negedge clk);
      power_off_i = 1;
      @(negedge clk);
      power_off_i = 0;
      chk(lane_en_o == 0 && turn_dis_o == 4'hF && force_rx_o == 0,
          "R9 power off", lane_en_o, 0);
      run(1500, 4, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule